// File: doc/BRIEF.md
# Broadcast-Lane Vector FIR Filter

This block is a four-tap FIR filter built as a row of accumulator lanes rather than a chain of delayed samples multiplied one at a time. Each accepted input sample is copied to every lane in the same cycle. The accumulator vector moves up by one lane, and a zero enters the bottom lane. Each lane then adds the product of the broadcast sample and its own coefficient. The tap delays come from the lane shift, so the block holds no separate line of past samples.

After an update, the top lane holds the complete output for the sample just taken. That value is rounded, saturated and presented on the output one cycle after the sample handshake. It leaves the top of the vector on the next sample.

Samples arrive on a valid/ready port. Coefficients are written one tap at a time through a load port. A synchronous clear empties the accumulator history. The output is a valid-qualified stream with no back-pressure.

Top module: `vfir_vector`

## Requirements
- R1: `in_ready` is high exactly when neither `clr` nor `coef_we` is high. A sample is taken in a cycle where `in_valid` and `in_ready` are both high, so a coefficient load or a clear holds an offered sample until a later cycle.
- R2: `out_valid` is high in the cycle after each accepted sample and low in every other cycle.
- R3: With coefficients b0..b3, where tap 0 weights the newest sample, the output for accepted sample x[n] is the sum of b_k*x[n-k] for k = 0..3. That sum is formed from the contents of the lane shift, and it then goes through R4 and R5. Samples accepted before reset or before the last clear count as zero.
- R4: The full-precision sum is in Q30 when samples and coefficients are read as Q15. It is scaled back by adding 2^14 and shifting right arithmetically by 15 bits, so exact halves round toward plus infinity.
- R5: A scaled result above 32767 gives 32767, and one below -32768 gives -32768.
- R6: A write with `coef_we` high stores `coef_data` as tap b_k, where k is the value on `coef_idx` (0 to 3). The new value weights samples accepted after the write. A partial sum already in a lane keeps the weight that was in force when its sample was accepted.
- R7: `clr` zeroes every accumulator lane in the next cycle. Outputs that follow depend only on samples accepted after the clear.
- R8: After reset, `out_valid` is low, every coefficient is zero and the lanes are empty, so an output produced before any coefficient write is 0.
- R9: Cycles in which no sample is accepted leave the lanes unchanged, so idle gaps in the input stream do not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all accumulator lanes |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Signed input sample (Q15) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 2 | Tap number written (0 = newest-sample tap) |
| coef_data | input | 16 | Signed coefficient value (Q15) |
| out_valid | output | 1 | Output sample present |
| out_data | output | 16 | Rounded, saturated signed output |

## Verification
The same cycle can carry a sample offer and a coefficient write, or a sample offer and a clear. Both collisions are forced by directed cycles and also occur at random during a long random run. Each is judged in three ways: `in_ready` must be low in that cycle, `out_valid` must stay low in the next cycle, and the held sample, once taken later, must produce the value a direct-form reference gives. That reference weights each past sample by the coefficients that were in force when it was accepted.

// File: rtl/vfir_pkg.sv
// Package: vfir_pkg
// Shared defaults and helpers for the broadcast-lane vector FIR.
// Assumes lane 0 is the bottom lane and lane NTAPS-1 is the output lane.
package vfir_pkg;

    localparam int VFIR_NTAPS    = 4;
    localparam int VFIR_SAMPLE_W = 16;
    localparam int VFIR_COEF_W   = 16;
    localparam int VFIR_ACC_W    = 40;
    localparam int VFIR_FRAC_W   = 15;

    // Tap number served by a given lane: the top lane weights the newest sample.
    function automatic int tap_of_lane(input int lane, input int ntaps);
        return ntaps - 1 - lane;
    endfunction

endpackage

// File: rtl/vfir_coef_bank.sv
// Module: vfir_coef_bank
// Holds one coefficient register per tap and writes one tap per cycle.
// Assumes an index at or above NTAPS writes nothing. Reset clears every tap to zero.
module vfir_coef_bank #(
    parameter int NTAPS  = 4,
    parameter int COEF_W = 16,
    localparam int IDX_W = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [COEF_W-1:0]             wr_data,
    output logic [NTAPS-1:0][COEF_W-1:0]  taps
);

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        // Tap register k: loaded when the write addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                taps[k] <= '0;
            end else if (wr_en && (int'(wr_idx) == k)) begin
                taps[k] <= wr_data;
            end
        end
    end

    // A cycle without a write leaves every tap unchanged.
    assert_coef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(taps));

    // A write lands in the addressed tap on the next cycle.
    assert_coef_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NTAPS)) |=> (taps[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/vfir_lane.sv
// Module: vfir_lane
// One accumulator lane. On a step it takes the value of the lane below, already shifted up,
// and adds the broadcast sample times this lane's coefficient.
// Assumes ACC_W >= SAMPLE_W + COEF_W and that clear has priority over step.
module vfir_lane #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int ACC_W    = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       step,
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic signed [COEF_W-1:0]   coef,
    input  logic signed [ACC_W-1:0]    carry_in,
    output logic signed [ACC_W-1:0]    acc_q,
    output logic signed [ACC_W-1:0]    acc_d
);

    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [PROD_W-1:0] prod;

    // Lane multiply: broadcast sample times lane coefficient.
    always_comb prod = x * coef;

    // Next lane value: shifted-in partial sum plus this lane's product.
    always_comb acc_d = carry_in + ACC_W'(prod);

    // Lane register: reset and clear empty it, a step loads the new sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_d;
        end
    end

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(acc_q));

endmodule

// File: rtl/vfir_out_stage.sv
// Module: vfir_out_stage
// Rounds the finished top-lane sum (half toward plus infinity), saturates it to OUT_W bits
// and registers it with a valid flag. Assumes FRAC_W >= 1.
module vfir_out_stage #(
    parameter int ACC_W  = 40,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic signed [ACC_W-1:0] top_next,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);

    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] BIAS   = ACC_W'(64'sd1 <<< (FRAC_W - 1));

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;
    logic        [OUT_W-1:0] clamped;

    // Rounding: add half an output step, then arithmetic shift back to output scale.
    always_comb begin
        biased = top_next + BIAS;
        scaled = biased >>> FRAC_W;
    end

    // Saturation: clamp the scaled value into the signed output range.
    always_comb begin
        if (scaled > SAT_HI) begin
            clamped = SAT_HI[OUT_W-1:0];
        end else if (scaled < SAT_LO) begin
            clamped = SAT_LO[OUT_W-1:0];
        end else begin
            clamped = scaled[OUT_W-1:0];
        end
    end

    // Output register: valid follows each step by one cycle, data is held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= step;
            if (step) begin
                out_data <= clamped;
            end
        end
    end

    assert_valid_after_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !out_valid);

    assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (top_next >= (SAT_HI <<< FRAC_W))) |=> (out_data == SAT_HI[OUT_W-1:0]));

endmodule

// File: rtl/vfir_vector.sv
// Module: vfir_vector
// Four-tap (default) FIR built from accumulator lanes. Every accepted sample is broadcast
// to all lanes. The lane vector shifts up one lane with zero entering the bottom, and each
// lane multiply-accumulates with its own coefficient. The top lane's new value is the
// output for that sample.
// Assumes clear and coefficient load both stall sample intake for their cycle.
module vfir_vector #(
    parameter int NTAPS    = vfir_pkg::VFIR_NTAPS,
    parameter int SAMPLE_W = vfir_pkg::VFIR_SAMPLE_W,
    parameter int COEF_W   = vfir_pkg::VFIR_COEF_W,
    parameter int ACC_W    = vfir_pkg::VFIR_ACC_W,
    parameter int FRAC_W   = vfir_pkg::VFIR_FRAC_W,
    localparam int IDX_W   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                coef_we,
    input  logic [IDX_W-1:0]    coef_idx,
    input  logic [COEF_W-1:0]   coef_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);

    logic                               step;
    logic [NTAPS-1:0][COEF_W-1:0]       taps;
    logic signed [ACC_W-1:0]            lane_q [NTAPS];
    logic signed [ACC_W-1:0]            lane_d [NTAPS];

    // Intake control: a load or a clear in this cycle holds back the sample.
    always_comb begin
        in_ready = !(clr || coef_we);
        step     = in_valid && in_ready;
    end

    vfir_coef_bank #(
        .NTAPS  (NTAPS),
        .COEF_W (COEF_W)
    ) i_coef_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_we),
        .wr_idx  (coef_idx),
        .wr_data (coef_data),
        .taps    (taps)
    );

    for (genvar i = 0; i < NTAPS; i++) begin : g_lane
        localparam int TAP = vfir_pkg::tap_of_lane(i, NTAPS);
        logic signed [ACC_W-1:0] below;

        // Shift source: the bottom lane takes zero, every other lane the one beneath it.
        if (i == 0) begin : g_bottom
            always_comb below = '0;
        end else begin : g_upper
            always_comb below = lane_q[i-1];
        end

        vfir_lane #(
            .SAMPLE_W (SAMPLE_W),
            .COEF_W   (COEF_W),
            .ACC_W    (ACC_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .step     (step),
            .x        ($signed(in_data)),
            .coef     ($signed(taps[TAP])),
            .carry_in (below),
            .acc_q    (lane_q[i]),
            .acc_d    (lane_d[i])
        );
    end

    vfir_out_stage #(
        .ACC_W  (ACC_W),
        .OUT_W  (SAMPLE_W),
        .FRAC_W (FRAC_W)
    ) i_out_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .top_next  (lane_d[NTAPS-1]),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assert_load_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_we && in_valid) |=> !out_valid);

    assert_clear_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && in_valid) |=> !out_valid);

    assert_accept_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_bottom_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clr) |=>
            (lane_q[0] == ACC_W'($past($signed(in_data)) * $past($signed(taps[NTAPS-1])))));

endmodule

// File: tb/test_vfir_vector.sv
module test_vfir_vector;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clr;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_data;
    logic        coef_we;
    logic [1:0]  coef_idx;
    logic [15:0] coef_data;
    logic        out_valid;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    int    hx [4];
    int    hb [4][4];
    int    cur_b [4];
    bit    exp_valid = 0;
    int    exp_data  = 0;
    string exp_tag   = "R3";
    string data_tag  = "R3";

    always #2.5 clk = ~clk;

    vfir_vector i_vfir_vector (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .coef_we   (coef_we),
        .coef_idx  (coef_idx),
        .coef_data (coef_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int round_sat(input longint y);
        longint r;
        r = (y + 64'sd16384) >>> 15;
        if (r > 32767)  return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    function automatic int ref_out();
        longint s = 0;
        for (int k = 0; k < 4; k++) s += longint'(hb[k][k]) * longint'(hx[k]);
        return round_sat(s);
    endfunction

    // One cycle: check last cycle's outputs, drive new inputs, update the reference model.
    task automatic cyc(input bit v, input int x, input bit c, input bit we, input int idx, input int d);
        bit acc;
        @(negedge clk);
        chk("R2", int'(out_valid), int'(exp_valid));
        if (exp_valid) chk(exp_tag, int'($signed(out_data)), exp_data);
        in_valid  = v;
        in_data   = 16'(x);
        clr       = c;
        coef_we   = we;
        coef_idx  = 2'(idx);
        coef_data = 16'(d);
        #1;
        chk("R1", int'(in_ready), int'(!(c || we)));
        acc = v && in_ready;
        if (c) for (int k = 0; k < 4; k++) hx[k] = 0;
        if (acc) begin
            for (int k = 3; k > 0; k--) begin
                hx[k] = hx[k-1];
                hb[k] = hb[k-1];
            end
            hx[0] = x;
            hb[0] = cur_b;
            exp_data = ref_out();
            exp_tag  = data_tag;
        end
        exp_valid = acc;
        if (we) cur_b[idx] = $signed(16'(d));
    endtask

    task automatic load(input int b0, input int b1, input int b2, input int b3);
        cyc(0, 0, 0, 1, 0, b0);
        cyc(0, 0, 0, 1, 1, b1);
        cyc(0, 0, 0, 1, 2, b2);
        cyc(0, 0, 0, 1, 3, b3);
    endtask

    task automatic send(input int x);
        cyc(1, x, 0, 0, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4; k++) begin
            hx[k] = 0;
            cur_b[k] = 0;
            for (int j = 0; j < 4; j++) hb[k][j] = 0;
        end
        rst_n = 1'b0; clr = 0; in_valid = 0; in_data = 0;
        coef_we = 0; coef_idx = 0; coef_data = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk("R8", int'(out_valid), 0);
        chk("R8", int'(in_ready), 1);
        data_tag = "R8";
        send(12345);
        send(-20000);
        idle();

        // R3: impulse response reproduces the coefficients
        data_tag = "R3";
        load(16384, -8192, 4096, 32767);
        send(32767); send(0); send(0); send(0); send(0);
        idle();
        // R3: step response
        cyc(0, 0, 1, 0, 0, 0);
        send(10000); send(10000); send(10000); send(10000); send(10000);
        // R9: idle gaps do not disturb the history
        data_tag = "R9";
        idle(); idle(); idle();
        send(-7000); idle(); send(3000); idle(); idle(); send(1);
        idle();

        // R5: full-scale saturation, both signs
        data_tag = "R5";
        load(-32768, -32768, -32768, -32768);
        cyc(0, 0, 1, 0, 0, 0);
        send(-32768); send(-32768); send(-32768); send(-32768);
        send(32767); send(32767); send(32767); send(32767);
        idle();

        // R4: exact halves round toward plus infinity
        data_tag = "R4";
        load(1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0);
        send(16384); send(-16384); send(16383); send(-16385); send(49152 - 65536);
        idle();

        // R6: coefficient change mid-stream, partial sums keep old weights
        data_tag = "R6";
        load(8000, 8000, 8000, 8000);
        send(20000); send(-15000);
        cyc(1, 9999, 0, 1, 0, -12000);   // R1: load stalls the offered sample
        cyc(1, 9999, 0, 1, 3, 5000);
        send(9999); send(4000); send(-4000); send(100);
        idle();

        // R7: clear with a sample offered, history starts over
        data_tag = "R7";
        send(30000); send(-30000);
        cyc(1, 22222, 1, 0, 0, 0);
        send(22222); send(-1111); send(5555);
        idle();

        // random phase: mixed offers, loads and clears
        data_tag = "R3";
        for (int i = 0; i < 4000; i++) begin
            int  x, d, r;
            bit  v, c, we;
            r  = $urandom_range(0, 99);
            v  = (r < 75);
            c  = ($urandom_range(0, 99) < 2);
            we = ($urandom_range(0, 99) < 6);
            case ($urandom_range(0, 7))
                0: x = 32767;
                1: x = -32768;
                default: x = $signed(16'($urandom));
            endcase
            d = ($urandom_range(0, 3) == 0) ? -32768 : $signed(16'($urandom));
            cyc(v, x, c, we, $urandom_range(0, 3), d);
        end
        idle(); idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule